// File: doc/BRIEF.md
# Timed Parallel Bus Master

This block is the host-side controller for a byte-addressed parallel programming bus. The slave on that bus has minimum setup, hold, pulse-width and access-time limits given in nanoseconds. The master drives an address, write data, an output enable for the shared data lines, and active-low read and write strobes. Each bus cycle is split into phases: an address/data setup phase, a strobe-low phase and a recovery phase. Every phase lasts a whole number of clock cycles. The count is the ceiling of the nanosecond limit divided by the clock period, and never less than one cycle.

A command is given as a one-cycle request while `ready` is high. The request carries a read/write flag, a width flag, an address and write data. The controller then runs the bus cycle on its own. When the cycle ends it raises `done` for one cycle, and `ready` rises in that same cycle. For reads, `rdData` already holds the captured word in that cycle.

A read waits until two limits have both passed: the address-to-valid limit and the strobe-to-valid limit. The word is sampled on the last cycle of the strobe-low phase. The master then keeps its data drivers off until the slave's release time after the strobe rises has passed.

Top module: `timed_pbus_master`

## Requirements
- R1: During and after reset `ready` is 1, `busWrN` and `busRdN` are 1, and `busOe` and `done` are 0.
- R2: A request is taken only when `reqValid` is high while `ready` is high, and `ready` falls in the next cycle. A `reqValid` pulse that arrives while `ready` is low starts no bus cycle and writes nothing.
- R3: While `busWrN` is low, `busOe` is high. `busAddr` and `busDout` are driven with `busOe` high for at least ceil(max(1 ns, 3.8 ns)/T) cycles before `busWrN` falls, and stay stable while it is low.
- R4: `busWrN` stays low for exactly ceil(2.1 ns/T) cycles. Between two falls of `busWrN`, the strobe is high for at least ceil(3.8 ns/T) cycles, and the span from fall to fall lasts at least 10.5 ns.
- R5: `busRdN` stays low for exactly max(ceil(69 ns/T), ceil(92 ns/T) − 1) cycles. The strobe falls one cycle after the read address is driven. `rdData` is the bus value seen on the last low cycle.
- R6: After `busRdN` rises, `busOe` stays low for at least ceil(50 ns/T) cycles, and `busRdN` stays high for at least ceil(50 ns/T) cycles before it falls again.
- R7: `busOe` is never high while `busRdN` is low, and the two strobes are never low together.
- R8: `busWide` follows the request's width flag. In narrow mode (flag 0), bits [15:8] of `busDout` and of `rdData` are zero. In wide mode (flag 1), bits [15:8] belong to the given address and bits [7:0] to the address one below, modulo 256 (so a wide transfer at address 0 pairs with address 255).
- R9: `done` is a single-cycle pulse and is high only while `ready` is high. For a read, `rdData` holds the captured word in the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request, taken when `ready` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWide | input | 1 | 1 = 16-bit transfer, 0 = 8-bit |
| reqAddr | input | ADDR_W | Target address |
| reqWdata | input | DATA_W | Write word |
| ready | output | 1 | Controller idle, may take a command |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Word captured by the last read |
| busAddr | output | ADDR_W | Address lines |
| busDout | output | DATA_W | Data driven toward the slave |
| busOe | output | 1 | Enable for the master's data drivers |
| busDin | input | DATA_W | Data seen on the bus lines |
| busRdN | output | 1 | Active-low read strobe |
| busWrN | output | 1 | Active-low write strobe |
| busWide | output | 1 | Width indication to the slave |

## Verification
The bench builds the block with a 4 ns clock period and the default nanosecond limits. With these values every write phase shrinks to one cycle, so the 10.5 ns full-cycle rule is the limit that binds the recovery phase. On reads, the address-to-valid limit (23 cycles from address change) sets the 22-cycle strobe width, not the strobe-to-valid rule. The bus model returns junk until both access limits have passed, so any shortened read phase shows up as wrong data. Wide transfers at address 0 reach the wrap to address 255.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  // Whole clock cycles covering a time limit, never fewer than one.
  function automatic int unsigned phaseCycles(int unsigned limitPs, int unsigned periodPs);
    int unsigned n;
    n = (limitPs + periodPs - 1) / periodPs;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSETUP,
    PH_WLOW,
    PH_WREC,
    PH_RADDR,
    PH_RLOW,
    PH_RREC
  } phase_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic accept;    // latch the command this cycle
    logic driveBus;  // output enable for the next cycle
    logic wrActive;  // write strobe low in the next cycle
    logic rdActive;  // read strobe low in the next cycle
    logic capture;   // sample the bus at this edge
    logic finish;    // raise done in the next cycle
  } busCtl_t;

endpackage

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS      = 4000,
  parameter int unsigned ADDR_SETUP_PS      = 1000,
  parameter int unsigned DATA_SETUP_PS      = 3800,
  parameter int unsigned WR_LOW_PS          = 2100,
  parameter int unsigned WR_HIGH_PS         = 3800,
  parameter int unsigned WR_CYCLE_PS        = 10500,
  parameter int unsigned RD_ADDR_VALID_PS   = 92000,
  parameter int unsigned RD_STROBE_VALID_PS = 69000,
  parameter int unsigned RD_LOW_PS          = 69000,
  parameter int unsigned RD_HIGH_PS         = 50000,
  parameter int unsigned RD_RELEASE_PS      = 50000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    ready,
  output busCtl_t ctl
);

  // Write phases
  localparam int unsigned WSETUP_CYC = maxOf(phaseCycles(ADDR_SETUP_PS, CLK_PERIOD_PS),
                                             phaseCycles(DATA_SETUP_PS, CLK_PERIOD_PS));
  localparam int unsigned WLOW_CYC   = phaseCycles(WR_LOW_PS, CLK_PERIOD_PS);
  localparam int unsigned WFULL_CYC  = phaseCycles(WR_CYCLE_PS, CLK_PERIOD_PS);
  localparam int unsigned WFILL_CYC  = (WFULL_CYC > WSETUP_CYC + WLOW_CYC)
                                       ? WFULL_CYC - WSETUP_CYC - WLOW_CYC : 1;
  localparam int unsigned WREC_CYC   = maxOf(phaseCycles(WR_HIGH_PS, CLK_PERIOD_PS), WFILL_CYC);

  // Read phases
  localparam int unsigned RADDR_CYC  = 1;
  localparam int unsigned RAV_CYC    = phaseCycles(RD_ADDR_VALID_PS, CLK_PERIOD_PS);
  localparam int unsigned RAV_LOW    = (RAV_CYC > RADDR_CYC) ? RAV_CYC - RADDR_CYC : 1;
  localparam int unsigned RLOW_CYC   = maxOf(maxOf(phaseCycles(RD_LOW_PS, CLK_PERIOD_PS),
                                                   phaseCycles(RD_STROBE_VALID_PS, CLK_PERIOD_PS)),
                                             RAV_LOW);
  localparam int unsigned RREC_CYC   = maxOf(phaseCycles(RD_HIGH_PS, CLK_PERIOD_PS),
                                             phaseCycles(RD_RELEASE_PS, CLK_PERIOD_PS));

  localparam int unsigned MAX_CYC    = maxOf(maxOf(WSETUP_CYC, WLOW_CYC),
                                             maxOf(WREC_CYC, maxOf(RLOW_CYC, RREC_CYC)));
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  phase_t             phase, phaseNext;
  logic [CNT_W-1:0]   cnt;
  logic               lastCycle;
  logic               advance;

  function automatic logic [CNT_W-1:0] phaseLoad(phase_t p);
    case (p)
      PH_WSETUP: return CNT_W'(WSETUP_CYC - 1);
      PH_WLOW:   return CNT_W'(WLOW_CYC - 1);
      PH_WREC:   return CNT_W'(WREC_CYC - 1);
      PH_RADDR:  return CNT_W'(RADDR_CYC - 1);
      PH_RLOW:   return CNT_W'(RLOW_CYC - 1);
      PH_RREC:   return CNT_W'(RREC_CYC - 1);
      default:   return '0;
    endcase
  endfunction

  assign lastCycle = (cnt == '0);

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:   if (reqValid) phaseNext = reqWrite ? PH_WSETUP : PH_RADDR;
      PH_WSETUP: if (lastCycle) phaseNext = PH_WLOW;
      PH_WLOW:   if (lastCycle) phaseNext = PH_WREC;
      PH_WREC:   if (lastCycle) phaseNext = PH_IDLE;
      PH_RADDR:  if (lastCycle) phaseNext = PH_RLOW;
      PH_RLOW:   if (lastCycle) phaseNext = PH_RREC;
      PH_RREC:   if (lastCycle) phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  assign advance = (phase == PH_IDLE) ? reqValid : lastCycle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      if (advance)          cnt <= phaseLoad(phaseNext);
      else if (!lastCycle)  cnt <= cnt - 1'b1;
    end
  end

  assign ready = (phase == PH_IDLE);

  always_comb begin
    ctl.accept   = (phase == PH_IDLE) && reqValid;
    ctl.driveBus = (phaseNext == PH_WSETUP) || (phaseNext == PH_WLOW) || (phaseNext == PH_WREC);
    ctl.wrActive = (phaseNext == PH_WLOW);
    ctl.rdActive = (phaseNext == PH_RLOW);
    ctl.capture  = (phase == PH_RLOW) && lastCycle;
    ctl.finish   = ((phase == PH_WREC) || (phase == PH_RREC)) && lastCycle;
  end

endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDin,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  output logic              busWrN,
  output logic              busRdN,
  output logic              busWide,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  localparam int unsigned LANES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] wrMasked;
  logic [DATA_W-1:0] rdMasked;

  // Lane 0 always carries data; upper lanes only in wide mode.
  for (genvar g = 0; g < LANES; g++) begin : gLane
    if (g == 0) begin : gBase
      assign wrMasked[g*BYTE_W +: BYTE_W] = reqWdata[g*BYTE_W +: BYTE_W];
      assign rdMasked[g*BYTE_W +: BYTE_W] = busDin[g*BYTE_W +: BYTE_W];
    end else begin : gUpper
      assign wrMasked[g*BYTE_W +: BYTE_W] = reqWide ? reqWdata[g*BYTE_W +: BYTE_W] : '0;
      assign rdMasked[g*BYTE_W +: BYTE_W] = busWide ? busDin[g*BYTE_W +: BYTE_W] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busAddr <= '0;
      busDout <= '0;
      busWide <= 1'b0;
      busOe   <= 1'b0;
      busWrN  <= 1'b1;
      busRdN  <= 1'b1;
      rdData  <= '0;
      done    <= 1'b0;
    end else begin
      if (ctl.accept) begin
        busAddr <= reqAddr;
        busDout <= wrMasked;
        busWide <= reqWide;
      end
      busOe  <= ctl.driveBus;
      busWrN <= !ctl.wrActive;
      busRdN <= !ctl.rdActive;
      if (ctl.capture) rdData <= rdMasked;
      done <= ctl.finish;
    end
  end

endmodule

// File: rtl/timed_pbus_master.sv
module timed_pbus_master
  import pbus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS      = 4000,
  parameter int unsigned ADDR_W             = 8,
  parameter int unsigned DATA_W             = 16,
  parameter int unsigned BYTE_W             = 8,
  parameter int unsigned ADDR_SETUP_PS      = 1000,
  parameter int unsigned DATA_SETUP_PS      = 3800,
  parameter int unsigned WR_LOW_PS          = 2100,
  parameter int unsigned WR_HIGH_PS         = 3800,
  parameter int unsigned WR_CYCLE_PS        = 10500,
  parameter int unsigned RD_ADDR_VALID_PS   = 92000,
  parameter int unsigned RD_STROBE_VALID_PS = 69000,
  parameter int unsigned RD_LOW_PS          = 69000,
  parameter int unsigned RD_HIGH_PS         = 50000,
  parameter int unsigned RD_RELEASE_PS      = 50000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWide,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDout,
  output logic              busOe,
  input  logic [DATA_W-1:0] busDin,
  output logic              busRdN,
  output logic              busWrN,
  output logic              busWide
);

  busCtl_t ctl;

  pbus_ctrl #(
    .CLK_PERIOD_PS      (CLK_PERIOD_PS),
    .ADDR_SETUP_PS      (ADDR_SETUP_PS),
    .DATA_SETUP_PS      (DATA_SETUP_PS),
    .WR_LOW_PS          (WR_LOW_PS),
    .WR_HIGH_PS         (WR_HIGH_PS),
    .WR_CYCLE_PS        (WR_CYCLE_PS),
    .RD_ADDR_VALID_PS   (RD_ADDR_VALID_PS),
    .RD_STROBE_VALID_PS (RD_STROBE_VALID_PS),
    .RD_LOW_PS          (RD_LOW_PS),
    .RD_HIGH_PS         (RD_HIGH_PS),
    .RD_RELEASE_PS      (RD_RELEASE_PS)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ready    (ready),
    .ctl      (ctl)
  );

  pbus_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqWide  (reqWide),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .busDin   (busDin),
    .busAddr  (busAddr),
    .busDout  (busDout),
    .busOe    (busOe),
    .busWrN   (busWrN),
    .busRdN   (busRdN),
    .busWide  (busWide),
    .rdData   (rdData),
    .done     (done)
  );

endmodule

// File: rtl/pbus_master_checker.sv
module pbus_master_checker
  import pbus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS      = 4000,
  parameter int unsigned ADDR_W             = 8,
  parameter int unsigned DATA_W             = 16,
  parameter int unsigned BYTE_W             = 8,
  parameter int unsigned WR_LOW_PS          = 2100,
  parameter int unsigned RD_LOW_PS          = 69000,
  parameter int unsigned RD_STROBE_VALID_PS = 69000,
  parameter int unsigned RD_RELEASE_PS      = 50000
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busDout,
  input logic              busOe,
  input logic              busRdN,
  input logic              busWrN,
  input logic              busWide
);

  localparam int unsigned REL_CYC    = phaseCycles(RD_RELEASE_PS, CLK_PERIOD_PS);
  localparam int unsigned RLOW_MIN   = maxOf(phaseCycles(RD_LOW_PS, CLK_PERIOD_PS),
                                             phaseCycles(RD_STROBE_VALID_PS, CLK_PERIOD_PS));
  localparam int unsigned WLOW_MIN   = phaseCycles(WR_LOW_PS, CLK_PERIOD_PS);
  localparam int unsigned WIN_MAX    = maxOf(REL_CYC, RLOW_MIN) + 2;
  localparam int unsigned WIN_W      = $clog2(WIN_MAX + 1);

  logic [WIN_W-1:0] sinceRdHigh;
  logic [WIN_W-1:0] rdLowRun;
  logic [WIN_W-1:0] wrLowRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRdHigh <= WIN_W'(WIN_MAX);
      rdLowRun    <= '0;
      wrLowRun    <= '0;
    end else begin
      if (!busRdN) sinceRdHigh <= '0;
      else if (sinceRdHigh != WIN_W'(WIN_MAX)) sinceRdHigh <= sinceRdHigh + 1'b1;
      if (!busRdN && rdLowRun != WIN_W'(WIN_MAX)) rdLowRun <= rdLowRun + 1'b1;
      else if (busRdN) rdLowRun <= '0;
      if (!busWrN && wrLowRun != WIN_W'(WIN_MAX)) wrLowRun <= wrLowRun + 1'b1;
      else if (busWrN) wrLowRun <= '0;
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && reqValid) |=> !ready);

  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> (busOe && $stable(busAddr) && $stable(busDout)));

  assert_wr_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWrN) |-> (wrLowRun >= WIN_W'(WLOW_MIN)));

  assert_rd_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRdN) |-> (rdLowRun >= WIN_W'(RLOW_MIN)));

  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (sinceRdHigh >= WIN_W'(REL_CYC)));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busOe && !busRdN));

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN));

  assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !busWide) |-> (busDout[DATA_W-1:BYTE_W] == '0));

  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind timed_pbus_master pbus_master_checker #(
  .CLK_PERIOD_PS      (CLK_PERIOD_PS),
  .ADDR_W             (ADDR_W),
  .DATA_W             (DATA_W),
  .BYTE_W             (BYTE_W),
  .WR_LOW_PS          (WR_LOW_PS),
  .RD_LOW_PS          (RD_LOW_PS),
  .RD_STROBE_VALID_PS (RD_STROBE_VALID_PS),
  .RD_RELEASE_PS      (RD_RELEASE_PS)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .ready    (ready),
  .done     (done),
  .busAddr  (busAddr),
  .busDout  (busDout),
  .busOe    (busOe),
  .busRdN   (busRdN),
  .busWrN   (busWrN),
  .busWide  (busWide)
);

// File: tb/timed_pbus_master_test.sv
module timed_pbus_master_test;

  localparam int CLK_PS = 4000;  // 250 MHz

  function automatic int cyc(int ps);
    int n;
    n = (ps + CLK_PS - 1) / CLK_PS;
    return (n < 1) ? 1 : n;
  endfunction

  localparam int EXP_WSETUP = 1;                         // ceil(max(1,3.8)/4)
  localparam int EXP_WLOW   = 1;                         // ceil(2.1/4)
  localparam int EXP_WHIGH  = 1;                         // ceil(3.8/4)
  localparam int EXP_RLOW   = 22;                        // max(18, 23-1)
  localparam int EXP_REL    = 13;                        // ceil(50/4)
  localparam int SLV_RSTB   = 18;                        // strobe-to-valid cycles
  localparam int SLV_RADDR  = 23;                        // address-to-valid cycles

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqWide = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        ready, done;
  logic [15:0] rdData;
  logic [7:0]  busAddr;
  logic [15:0] busDout;
  logic        busOe;
  logic [15:0] busDin = 16'hDEAD;
  logic        busRdN, busWrN, busWide;

  int checks = 0;
  int errors = 0;
  int expWrites = 0;
  int slaveWrites = 0;

  logic [7:0] refMem [256];
  logic [7:0] slaveMem [256];

  always #2 clk = ~clk;

  timed_pbus_master #(.CLK_PERIOD_PS(CLK_PS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqWide(reqWide),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .ready(ready), .done(done), .rdData(rdData),
    .busAddr(busAddr), .busDout(busDout), .busOe(busOe), .busDin(busDin),
    .busRdN(busRdN), .busWrN(busWrN), .busWide(busWide)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] expRead(bit wide, logic [7:0] a);
    logic [7:0] lo;
    lo = a - 8'd1;
    return wide ? {refMem[a], refMem[lo]} : {8'h00, refMem[a]};
  endfunction

  // Bus slave model and timing monitor
  logic        pWrN = 1'b1, pRdN = 1'b1, pOe = 1'b0;
  logic [7:0]  pAddr = '0;
  logic [15:0] pDout = '0;
  int wrLowRun = 0, rdLowRun = 0, wrHighRun = 0, sinceRd = 1000, addrAge = 0;
  int cycleNo = 0, lastWrFall = -1;

  always @(negedge clk) begin
    if (rstN) begin
      cycleNo++;
      if (pWrN && !busWrN) begin
        check(pOe && pAddr == busAddr && pDout == busDout, "R3", "setup before strobe",
              {pOe, pAddr, pDout}, {1'b1, busAddr, busDout});
        if (lastWrFall >= 0) begin
          check((cycleNo - lastWrFall) * CLK_PS >= 10500, "R4", "write period ps",
                (cycleNo - lastWrFall) * CLK_PS, 10500);
          check(wrHighRun >= EXP_WHIGH, "R4", "strobe high cycles", wrHighRun, EXP_WHIGH);
        end
        lastWrFall = cycleNo;
        slaveWrites++;
        if (busWide) begin
          slaveMem[busAddr] = busDout[15:8];
          slaveMem[busAddr - 8'd1] = busDout[7:0];
        end else begin
          slaveMem[busAddr] = busDout[7:0];
        end
      end
      if (!pWrN && busWrN)
        check(wrLowRun == EXP_WLOW, "R4", "write low cycles", wrLowRun, EXP_WLOW);
      if (pRdN && !busRdN)
        check(sinceRd >= EXP_REL, "R6", "read high cycles", sinceRd, EXP_REL);
      if (!pRdN && busRdN)
        check(rdLowRun == EXP_RLOW, "R5", "read low cycles", rdLowRun, EXP_RLOW);
      check(!(busOe && !busRdN) && !(!busRdN && !busWrN), "R7", "contention",
            {busOe, busRdN, busWrN}, 3'b011);
      if (busOe) begin
        check(sinceRd > EXP_REL, "R6", "drive after release", sinceRd, EXP_REL + 1);
        if (!busWide)
          check(busDout[15:8] == 8'h00, "R8", "narrow upper byte", busDout[15:8], 0);
      end
      // update run counters
      wrLowRun  = busWrN ? 0 : wrLowRun + 1;
      wrHighRun = busWrN ? wrHighRun + 1 : 0;
      rdLowRun  = busRdN ? 0 : rdLowRun + 1;
      if (!pRdN && busRdN) sinceRd = 1;
      else if (busRdN && sinceRd < 1000) sinceRd++;
      else if (!busRdN) sinceRd = 0;
      addrAge = (busAddr != pAddr) ? 1 : ((addrAge < 1000) ? addrAge + 1 : addrAge);
      if (!busRdN && rdLowRun >= SLV_RSTB && addrAge >= SLV_RADDR)
        busDin = busWide ? {slaveMem[busAddr], slaveMem[busAddr - 8'd1]}
                         : {8'h00, slaveMem[busAddr]};
      else
        busDin = 16'hDEAD;
      pWrN = busWrN; pRdN = busRdN; pOe = busOe; pAddr = busAddr; pDout = busDout;
    end
  end

  task automatic doTxn(bit wr, bit wide, logic [7:0] a, logic [15:0] d);
    logic [15:0] exp;
    int g;
    exp = expRead(wide, a);
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWide = wide; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    check(ready == 1'b0, "R2", "busy after accept", ready, 0);
    g = 0;
    while (!done && g < 500) begin @(negedge clk); g++; end
    check(done == 1'b1, "R9", "done seen", done, 1);
    check(ready == 1'b1, "R9", "ready with done", ready, 1);
    if (!wr) check(rdData == exp, "R5", "read data", rdData, exp);
    @(negedge clk);
    check(done == 1'b0, "R9", "done one cycle", done, 0);
    if (wr) begin
      expWrites++;
      if (wide) begin
        refMem[a] = d[15:8];
        refMem[a - 8'd1] = d[7:0];
      end else begin
        refMem[a] = d[7:0];
      end
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] exp;
    int beforeWr;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      refMem[i] = 8'(i * 7 + 3);
      slaveMem[i] = 8'(i * 7 + 3);
    end
    repeat (4) @(negedge clk);
    check(ready == 1 && busWrN == 1 && busRdN == 1 && busOe == 0 && done == 0,
          "R1", "in reset", {ready, busWrN, busRdN, busOe, done}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1 && busWrN == 1 && busRdN == 1 && busOe == 0 && done == 0,
          "R1", "after reset", {ready, busWrN, busRdN, busOe, done}, 5'b11100);

    // R8: wide write at address 0 wraps its low byte to 255
    doTxn(1'b1, 1'b1, 8'h00, 16'hA55A);
    doTxn(1'b0, 1'b0, 8'hFF, 16'h0);
    doTxn(1'b0, 1'b0, 8'h00, 16'h0);
    doTxn(1'b0, 1'b1, 8'h00, 16'h0);
    check(busWide == 1'b1, "R8", "wide flag on bus", busWide, 1);
    doTxn(1'b1, 1'b0, 8'h80, 16'hFF3C);
    doTxn(1'b0, 1'b1, 8'h81, 16'h0);
    check(busWide == 1'b1, "R8", "wide flag on bus", busWide, 1);
    doTxn(1'b0, 1'b0, 8'h80, 16'h0);
    check(rdData[15:8] == 8'h00, "R8", "narrow read upper", rdData[15:8], 0);

    // R2: a request raised while busy is ignored
    while (!ready) @(negedge clk);
    exp = expRead(1'b0, 8'd10);
    beforeWr = slaveWrites;
    reqValid = 1'b1; reqWrite = 1'b0; reqWide = 1'b0; reqAddr = 8'd10;
    @(negedge clk);
    reqWrite = 1'b1; reqAddr = 8'd20; reqWdata = 16'h00EE;
    repeat (10) @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    check(rdData == exp, "R5", "read under busy request", rdData, exp);
    @(negedge clk);
    check(slaveWrites == beforeWr, "R2", "no write while busy", slaveWrites, beforeWr);
    doTxn(1'b0, 1'b0, 8'd20, 16'h0);

    // Random mix, back-to-back read/write turnarounds included (R6)
    for (int i = 0; i < 80; i++) begin
      bit wr, wide;
      logic [7:0] a;
      logic [15:0] d;
      wr   = 1'($urandom % 2);
      wide = 1'($urandom % 2);
      a    = 8'($urandom);
      d    = 16'($urandom);
      if (i % 10 == 0) a = 8'h00;
      doTxn(wr, wide, a, d);
    end

    check(slaveWrites == expWrites, "R3", "write strobes issued", slaveWrites, expWrites);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 256; i++) if (slaveMem[i] != refMem[i]) bad++;
      check(bad == 0, "R8", "byte placement", bad, 0);
    end
    finishRun();
  end

endmodule